// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block is the device side of a serial NOR flash, working on whole bytes. An external bit shifter frames each transaction with an active-low select. It hands over each received byte with a one-cycle strobe. It pulls outgoing bytes by pulsing a request, and the byte to send is always shown on `tx_data_o`. Behind the engine sits an on-chip byte array of `2**ADDR_W` bytes, at least 64 KiB.

Each frame begins with an opcode. Depending on the opcode, the engine may collect a most-significant-first address of three bytes, or four bytes in wide-address mode. It then streams array bytes out, merges programmed bytes into the array, or blanks a region of it. A two-bit status word reports the busy flag and the write-enable latch. A fixed three-byte identity answers the identify command. Program and erase complete at once, and the busy flag stays set until the host reads status.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset the status word is 0x00, `err_o` is 0, the engine expects 3-byte addresses, and `tx_data_o` is 0x00 while no command is active.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Opcode 0x05 streams the status word, which carries busy in bit 0 and write-enable in bit 1, with all other bits 0.
- R3: Opcode 0x9F returns 0x55, 0xAA, 0x55, and then 0x00 for every further byte in the frame.
- R4: Opcode 0x03 takes the address most-significant byte first and returns consecutive array bytes. The address increments linearly, so a read crosses 256-byte page boundaries.
- R5: Opcode 0xB7 makes every later address 4 bytes long, and opcode 0xE9 returns to 3-byte addresses.
- R6: Opcode 0x02 ANDs each data byte into the addressed array byte, so bits only go from 1 to 0. The erased value is 0xFF.
- R7: During a program, only the low 8 address bits advance, so writing wraps within the current 256-byte page.
- R8: When write-enable is clear, program (0x02), sector and block erase (0x20, 0x52, 0xD8) and chip erase (0x60) leave the array and the status word unchanged.
- R9: A program that had write-enable set sets busy and clears write-enable when the select is released.
- R10: Opcodes 0x20, 0x52 and 0xD8 blank the aligned 4 KiB, 32 KiB or 64 KiB region that contains the address to 0xFF. This happens when the last address byte arrives, and at that moment busy is set and write-enable is cleared.
- R11: With write-enable set, opcode 0x60 blanks the whole array, sets busy and clears write-enable as soon as the opcode is taken.
- R12: Busy clears after each status byte has been sent.
- R13: An unknown opcode, or an address at or beyond the array size, sets `err_o`, which stays set until reset. The rest of that frame is ignored.
- R14: Releasing the select always returns the engine to idle, so the next received byte is taken as an opcode, even if the previous command was cut off mid-address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Frame select, active low |
| rx_valid_i | input | 1 | One-cycle strobe: a received byte is on `rx_data_i` |
| rx_data_i | input | 8 | Received byte |
| tx_req_i | input | 1 | One-cycle strobe: the byte on `tx_data_o` has been taken |
| tx_data_o | output | 8 | Byte to transmit next |
| err_o | output | 1 | Sticky error flag |

## Verification
The hardest case to reach is erase-region alignment. The engine must blank exactly the aligned region around an unaligned address and leave the neighbouring bytes untouched. The stimulus first chip-erases the array. It then programs markers at the byte just before and just after each region, and at both of the region's own edges. Next it issues a 4 KiB erase and a 32 KiB erase at addresses inside the regions, and reads every marker back. The page-wrap path is handled the same way: a program starts two bytes before a page end, and a linear read then runs over that end to show the difference between the two address rules.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDIS = 8'h04;
    localparam logic [7:0] OP_RDST  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_ER4K  = 8'h20;
    localparam logic [7:0] OP_ER32K = 8'h52;
    localparam logic [7:0] OP_CHIP  = 8'h60;
    localparam logic [7:0] OP_IDENT = 8'h9F;
    localparam logic [7:0] OP_WIDE  = 8'hB7;
    localparam logic [7:0] OP_ER64K = 8'hD8;
    localparam logic [7:0] OP_NARROW = 8'hE9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RD,
        ST_PP,
        ST_ID,
        ST_SR,
        ST_DRAIN
    } state_e;

    typedef enum logic [3:0] {
        K_BAD,
        K_READ,
        K_PROG,
        K_RDST,
        K_WREN,
        K_WRDIS,
        K_ERASE,
        K_CHIP,
        K_IDENT,
        K_WIDE,
        K_NARROW
    } kind_e;

    typedef struct packed {
        state_e      state;
        kind_e       kind;
        logic [31:0] addr;
        logic [2:0]  acnt;
        logic [1:0]  idx;
        logic [4:0]  elg;
        logic        wip;
        logic        wen;
        logic        wide;
        logic        err;
    } eng_t;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [7:0] op_i,
    output kind_e      kind_o,
    output logic [4:0] erase_lg_o
);
    always_comb begin
        erase_lg_o = 5'd0;
        case (op_i)
            OP_PROG:   kind_o = K_PROG;
            OP_READ:   kind_o = K_READ;
            OP_WRDIS:  kind_o = K_WRDIS;
            OP_RDST:   kind_o = K_RDST;
            OP_WREN:   kind_o = K_WREN;
            OP_CHIP:   kind_o = K_CHIP;
            OP_IDENT:  kind_o = K_IDENT;
            OP_WIDE:   kind_o = K_WIDE;
            OP_NARROW: kind_o = K_NARROW;
            OP_ER4K: begin
                kind_o     = K_ERASE;
                erase_lg_o = 5'd12;
            end
            OP_ER32K: begin
                kind_o     = K_ERASE;
                erase_lg_o = 5'd15;
            end
            OP_ER64K: begin
                kind_o     = K_ERASE;
                erase_lg_o = 5'd16;
            end
            default:   kind_o = K_BAD;
        endcase
    end
endmodule

// File: rtl/flash_id_table.sv
module flash_id_table #(
    parameter logic [7:0] ID0 = 8'h55,
    parameter logic [7:0] ID1 = 8'hAA,
    parameter logic [7:0] ID2 = 8'h55
) (
    input  logic [1:0] idx_i,
    output logic [7:0] byte_o
);
    always_comb begin
        case (idx_i)
            2'd0:    byte_o = ID0;
            2'd1:    byte_o = ID1;
            2'd2:    byte_o = ID2;
            default: byte_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
    parameter int ADDR_W = 16,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    input  logic              pgm_en_i,
    input  logic [ADDR_W-1:0] pgm_addr_i,
    input  logic [7:0]        pgm_data_i,
    input  logic              ers_en_i,
    input  logic [ADDR_W-1:0] ers_base_i,
    input  logic [4:0]        ers_lg_i
);
    localparam int LANE_W = $clog2(LANES);
    localparam int WORDS  = (1 << ADDR_W) / LANES;
    localparam int WIDX_W = ADDR_W - LANE_W;

    logic [LANES*8-1:0] mem_q [WORDS];

    logic [WIDX_W-1:0] rd_w, pg_w;
    logic [LANE_W-1:0] rd_l, pg_l;

    assign rd_w = rd_addr_i[ADDR_W-1:LANE_W];
    assign rd_l = rd_addr_i[LANE_W-1:0];
    assign pg_w = pgm_addr_i[ADDR_W-1:LANE_W];
    assign pg_l = pgm_addr_i[LANE_W-1:0];

    assign rd_data_o = mem_q[rd_w][rd_l*8 +: 8];

    always_ff @(posedge clk) begin
        if (ers_en_i) begin
            for (int w = 0; w < WORDS; w++) begin
                if (((ADDR_W'(w) << LANE_W) >> ers_lg_i) == (ers_base_i >> ers_lg_i))
                    mem_q[w] <= '1;
            end
        end else if (pgm_en_i) begin
            mem_q[pg_w][pg_l*8 +: 8] <= mem_q[pg_w][pg_l*8 +: 8] & pgm_data_i;
        end
    end

    // R10
    ers_pgm_excl_chk: assert property (@(posedge clk) !(ers_en_i && pgm_en_i));

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W = 16,
    parameter logic [7:0] ID0    = 8'h55,
    parameter logic [7:0] ID1    = 8'hAA,
    parameter logic [7:0] ID2    = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_data_i,
    input  logic       tx_req_i,
    output logic [7:0] tx_data_o,
    output logic       err_o
);
    localparam logic [4:0] CHIP_LG = 5'(ADDR_W);

    eng_t q, d;

    kind_e             dec_kind;
    logic [4:0]        dec_lg;
    logic [7:0]        id_byte;
    logic [7:0]        rd_byte;
    logic              pgm_en, ers_en;
    logic [ADDR_W-1:0] ers_base;
    logic [4:0]        ers_lg;
    logic [31:0]       full_addr;
    logic [2:0]        need;
    logic              cur_in_range, full_in_range;

    flash_cmd_decode u_dec (
        .op_i       (rx_data_i),
        .kind_o     (dec_kind),
        .erase_lg_o (dec_lg)
    );

    flash_id_table #(.ID0(ID0), .ID1(ID1), .ID2(ID2)) u_id (
        .idx_i  (q.idx),
        .byte_o (id_byte)
    );

    flash_byte_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk        (clk),
        .rd_addr_i  (q.addr[ADDR_W-1:0]),
        .rd_data_o  (rd_byte),
        .pgm_en_i   (pgm_en),
        .pgm_addr_i (q.addr[ADDR_W-1:0]),
        .pgm_data_i (rx_data_i),
        .ers_en_i   (ers_en),
        .ers_base_i (ers_base),
        .ers_lg_i   (ers_lg)
    );

    assign full_addr     = {q.addr[23:0], rx_data_i};
    assign need          = q.wide ? 3'd4 : 3'd3;
    assign cur_in_range  = (q.addr >> ADDR_W) == 32'd0;
    assign full_in_range = (full_addr >> ADDR_W) == 32'd0;
    assign err_o         = q.err;

    always_comb begin
        d         = q;
        pgm_en    = 1'b0;
        ers_en    = 1'b0;
        ers_base  = full_addr[ADDR_W-1:0];
        ers_lg    = q.elg;
        tx_data_o = 8'h00;

        case (q.state)
            ST_RD:   tx_data_o = cur_in_range ? rd_byte : 8'h00;
            ST_ID:   tx_data_o = id_byte;
            ST_SR:   tx_data_o = {6'b0, q.wen, q.wip};
            default: tx_data_o = 8'h00;
        endcase

        if (cs_n_i) begin
            if (q.state == ST_PP) begin
                d.wip = 1'b1;
                d.wen = 1'b0;
            end
            d.state = ST_IDLE;
        end else begin
            case (q.state)
                ST_IDLE: if (rx_valid_i) begin
                    d.addr  = 32'd0;
                    d.acnt  = 3'd0;
                    d.idx   = 2'd0;
                    d.kind  = dec_kind;
                    d.elg   = dec_lg;
                    d.state = ST_DRAIN;
                    case (dec_kind)
                        K_READ:   d.state = ST_ADDR;
                        K_PROG:   if (q.wen) d.state = ST_ADDR;
                        K_ERASE:  if (q.wen) d.state = ST_ADDR;
                        K_RDST:   d.state = ST_SR;
                        K_IDENT:  d.state = ST_ID;
                        K_WREN:   d.wen = 1'b1;
                        K_WRDIS:  d.wen = 1'b0;
                        K_WIDE:   d.wide = 1'b1;
                        K_NARROW: d.wide = 1'b0;
                        K_CHIP: if (q.wen) begin
                            ers_en   = 1'b1;
                            ers_base = '0;
                            ers_lg   = CHIP_LG;
                            d.wip    = 1'b1;
                            d.wen    = 1'b0;
                        end
                        default:  d.err = 1'b1;
                    endcase
                end
                ST_ADDR: if (rx_valid_i) begin
                    d.addr = full_addr;
                    d.acnt = q.acnt + 3'd1;
                    if (d.acnt == need) begin
                        if (!full_in_range) begin
                            d.err   = 1'b1;
                            d.state = ST_DRAIN;
                        end else begin
                            case (q.kind)
                                K_READ: d.state = ST_RD;
                                K_PROG: d.state = ST_PP;
                                default: begin
                                    ers_en  = 1'b1;
                                    d.wip   = 1'b1;
                                    d.wen   = 1'b0;
                                    d.state = ST_DRAIN;
                                end
                            endcase
                        end
                    end
                end
                ST_RD: if (tx_req_i) begin
                    if (!cur_in_range) begin
                        d.err   = 1'b1;
                        d.state = ST_DRAIN;
                    end else begin
                        d.addr = q.addr + 32'd1;
                    end
                end
                ST_PP: if (rx_valid_i) begin
                    pgm_en = 1'b1;
                    d.addr = {q.addr[31:8], q.addr[7:0] + 8'd1};
                end
                ST_ID: if (tx_req_i && q.idx != 2'd3) d.idx = q.idx + 2'd1;
                ST_SR: if (tx_req_i) d.wip = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R14
    idle_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> q.state == ST_IDLE);
    // R8
    pgm_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_en |-> q.wen);
    // R10
    erase_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ers_en |=> (q.wip && !q.wen));
    // R7
    page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_PP && rx_valid_i && !cs_n_i) |=> q.addr[31:8] == $past(q.addr[31:8]));
    // R13
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |=> q.err);
    // R12
    sr_wip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SR && tx_req_i && !cs_n_i) |=> !q.wip);

endmodule

// File: tb/tb_flash_cmd_engine.sv
module tb_flash_cmd_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n_i = 1'b1;
    logic       rx_valid_i = 1'b0;
    logic [7:0] rx_data_i = 8'h00;
    logic       tx_req_i = 1'b0;
    logic [7:0] tx_data_o;
    logic       err_o;

    int n_chk = 0;
    int n_err = 0;
    bit wide = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_engine dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .rx_valid_i(rx_valid_i),
        .rx_data_i(rx_data_i), .tx_req_i(tx_req_i), .tx_data_o(tx_data_o), .err_o(err_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs_n_i = 1'b1; wide = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cs_on();
        @(negedge clk); cs_n_i = 1'b0;
    endtask

    task automatic cs_off();
        @(negedge clk); cs_n_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); rx_valid_i = 1'b1; rx_data_i = b;
        @(negedge clk); rx_valid_i = 1'b0;
    endtask

    task automatic take(output logic [7:0] b);
        @(negedge clk); b = tx_data_o; tx_req_i = 1'b1;
        @(negedge clk); tx_req_i = 1'b0;
    endtask

    task automatic put_addr(input logic [31:0] a);
        if (wide) put(a[31:24]);
        put(a[23:16]); put(a[15:8]); put(a[7:0]);
    endtask

    task automatic simple(input logic [7:0] op);
        cs_on(); put(op); cs_off();
    endtask

    task automatic status(output logic [7:0] s);
        cs_on(); put(8'h05); take(s); cs_off();
    endtask

    task automatic rd1(input logic [31:0] a, output logic [7:0] b);
        cs_on(); put(8'h03); put_addr(a); take(b); cs_off();
    endtask

    task automatic prog1(input logic [31:0] a, input logic [7:0] b);
        logic [7:0] s;
        simple(8'h06);
        cs_on(); put(8'h02); put_addr(a); put(b); cs_off();
        status(s);
    endtask

    task automatic erase(input logic [7:0] op, input logic [31:0] a);
        logic [7:0] s;
        simple(8'h06);
        cs_on(); put(op); put_addr(a); cs_off();
        status(s);
    endtask

    task automatic chip_erase();
        logic [7:0] s;
        simple(8'h06); simple(8'h60); status(s);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R1 err after reset", err_o, 0);
        chk("R1 idle tx", tx_data_o, 8'h00);
        status(s);
        chk("R1 status after reset", s, 8'h00);
    endtask

    task automatic t_wen();
        logic [7:0] s;
        simple(8'h06); status(s);
        chk("R2 wen set", s, 8'h02);
        simple(8'h04); status(s);
        chk("R2 wen cleared", s, 8'h00);
    endtask

    task automatic t_ident();
        logic [7:0] b;
        cs_on(); put(8'h9F);
        take(b); chk("R3 id0", b, 8'h55);
        take(b); chk("R3 id1", b, 8'hAA);
        take(b); chk("R3 id2", b, 8'h55);
        take(b); chk("R3 id3", b, 8'h00);
        take(b); chk("R3 id4", b, 8'h00);
        cs_off();
    endtask

    task automatic t_chip();
        logic [7:0] s, b;
        prog1(32'h0040, 8'h00);
        simple(8'h06); simple(8'h60); status(s);
        chk("R11 chip erase status", s, 8'h01);
        rd1(32'h0040, b);
        chk("R11 blanked", b, 8'hFF);
        rd1(32'hFFFF, b);
        chk("R11 last byte", b, 8'hFF);
    endtask

    task automatic t_and();
        logic [7:0] b;
        prog1(32'h0040, 8'h0F);
        prog1(32'h0040, 8'hF3);
        rd1(32'h0040, b);
        chk("R6 and merge", b, 8'h03);
    endtask

    task automatic t_pp_status();
        logic [7:0] s;
        simple(8'h06);
        cs_on(); put(8'h02); put_addr(32'h0080); put(8'h11);
        @(negedge clk);
        cs_off();
        cs_on(); put(8'h05);
        take(s); chk("R9 pp done status", s, 8'h01);
        take(s); chk("R12 wip cleared after byte", s, 8'h00);
        cs_off();
    endtask

    task automatic t_wrap_and_read();
        logic [7:0] b;
        logic [7:0] s;
        simple(8'h06);
        cs_on(); put(8'h02); put_addr(32'h12FE);
        put(8'hA0); put(8'hA1); put(8'hA2); cs_off();
        status(s);
        rd1(32'h1200, b); chk("R7 wrapped byte", b, 8'hA2);
        rd1(32'h1300, b); chk("R7 next page untouched", b, 8'hFF);
        cs_on(); put(8'h03); put_addr(32'h12FE);
        take(b); chk("R4 rd0", b, 8'hA0);
        take(b); chk("R4 rd1", b, 8'hA1);
        take(b); chk("R4 linear past page", b, 8'hFF);
        cs_off();
    endtask

    task automatic t_wide();
        logic [7:0] b;
        simple(8'hB7); wide = 1'b1;
        rd1(32'h000012FE, b); chk("R5 wide read", b, 8'hA0);
        simple(8'hE9); wide = 1'b0;
        rd1(32'h0012FF, b); chk("R5 narrow again", b, 8'hA1);
    endtask

    task automatic t_no_wen();
        logic [7:0] b, s;
        cs_on(); put(8'h02); put_addr(32'h0040); put(8'h00); cs_off();
        status(s); chk("R8 pp no wen status", s, 8'h00);
        cs_on(); put(8'h20); put_addr(32'h0040); cs_off();
        cs_on(); put(8'hD8); put_addr(32'h0040); cs_off();
        simple(8'h60);
        status(s); chk("R8 erase no wen status", s, 8'h00);
        rd1(32'h0040, b); chk("R8 array kept", b, 8'h03);
    endtask

    task automatic t_erase_regions();
        logic [7:0] b, s;
        chip_erase();
        prog1(32'h1FFF, 8'h00); prog1(32'h2000, 8'h00);
        prog1(32'h2FFF, 8'h00); prog1(32'h3000, 8'h00);
        simple(8'h06);
        cs_on(); put(8'h20); put_addr(32'h2345); cs_off();
        status(s); chk("R10 sector status", s, 8'h01);
        rd1(32'h1FFF, b); chk("R10 below sector", b, 8'h00);
        rd1(32'h2000, b); chk("R10 sector start", b, 8'hFF);
        rd1(32'h2FFF, b); chk("R10 sector end", b, 8'hFF);
        rd1(32'h3000, b); chk("R10 above sector", b, 8'h00);
        prog1(32'h7FFF, 8'h00); prog1(32'h8000, 8'h00); prog1(32'hFFFF, 8'h00);
        erase(8'h52, 32'h9000);
        rd1(32'h7FFF, b); chk("R10 below block32", b, 8'h00);
        rd1(32'h8000, b); chk("R10 block32 start", b, 8'hFF);
        rd1(32'hFFFF, b); chk("R10 block32 end", b, 8'hFF);
        erase(8'hD8, 32'h0123);
        rd1(32'h7FFF, b); chk("R10 block64", b, 8'hFF);
        rd1(32'h3000, b); chk("R10 block64 low", b, 8'hFF);
    endtask

    task automatic t_abort();
        logic [7:0] b;
        cs_on(); put(8'h03); put(8'h00); cs_off();
        cs_on(); put(8'h9F); take(b); cs_off();
        chk("R14 opcode after abort", b, 8'h55);
    endtask

    task automatic t_errors();
        logic [7:0] b, s;
        do_reset();
        cs_on(); put(8'hAB); put(8'h06); cs_off();
        chk("R13 bad opcode err", err_o, 1);
        status(s); chk("R13 rest of frame ignored", s, 8'h00);
        do_reset();
        chk("R13 err cleared by reset", err_o, 0);
        cs_on(); put(8'h03); put_addr(32'h010000); take(b); cs_off();
        chk("R13 range err", err_o, 1);
        chk("R13 range data", b, 8'h00);
        simple(8'h06);
        chk("R13 err sticky", err_o, 1);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_wen();
        t_ident();
        chip_erase();
        t_chip();
        t_and();
        t_pp_status();
        t_wrap_and_read();
        t_wide();
        t_no_wen();
        t_erase_regions();
        t_abort();
        t_errors();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #500000;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end
endmodule